// File: doc/BRIEF.md
# Widening Multiply-Accumulate Unit

This execute-stage unit of a 64-bit integer datapath multiplies 32-bit halves of two 64-bit source values. A decoded operation code tells it which half of each source to use (upper or lower), whether the halves are signed or unsigned, whether to add a 64-bit addend, and whether to return the whole 64-bit result or only its low 32 bits extended back to 64 bits. Choosing the half inside the unit means software needs no shift to reach an upper half. Folding the addend into the pipeline means a multiply-add costs no more cycles than a plain multiply.

Operations enter with `op_vld` and come out three clock cycles later with `res_vld`. A new operation can enter every cycle and there is no backpressure. An immediate multiplier is passed in the lower half of `src_b`. The flush input cancels every operation still in the pipeline.

Top module: `wmac_unit`

## Requirements
- R1: While `rst_n` is low and just after it rises, `res_vld` is 0 and `res` is 0.
- R2: An operation presented with `op_vld=1` and `flush=0` before clock edge k appears on `res`, with `res_vld=1`, after edge k+2. Operations presented on consecutive cycles come out on consecutive cycles.
- R3: `op_code` bit 5 set selects `src_a[63:32]` as the A factor; clear selects `src_a[31:0]`. Bit 4 selects the half of `src_b` in the same way.
- R4: `op_code` bit 3 set treats both selected halves as two's-complement numbers (sign-extended). Clear treats them as unsigned (zero-extended).
- R5: With `op_code` bit 2 clear, `res` is the full 64-bit product, plus the addend when accumulation is enabled.
- R6: With `op_code` bit 2 set, `res` holds bits 31:0 of that 64-bit value. The upper 32 bits are copies of bit 31 when `op_code` bit 1 is set, and zeros when it is clear.
- R7: `op_code` bit 0 set adds `addend` to the product, modulo 2^64, before any narrowing. The latency is the same as a plain multiply.
- R8: An immediate placed in `src_b[31:0]`, with bit 4 clear and accumulation enabled, gives `addend + A*imm`.
- R9: `flush=1` before an edge cancels every operation in flight, including one offered in the same cycle. No `res_vld` pulse comes from any of them.
- R10: `res_vld` is 0 in every cycle for which no operation was issued three cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel all in-flight operations |
| op_vld | input | 1 | Operation present this cycle |
| op_code | input | 6 | {a_hi, b_hi, signed, narrow, narrow_sext, accumulate} |
| src_a | input | 64 | Source A (two 32-bit halves) |
| src_b | input | 64 | Source B or immediate in the low half |
| addend | input | 64 | Value added when accumulating |
| res_vld | output | 1 | Result valid |
| res | output | 64 | Result |

## Verification
Every result is due three rising edges after the inputs are driven: one edge through operand selection, one through the multiply and one through the add and extend. The bench drives inputs on falling edges and samples `res` and `res_vld` on the third falling edge after the drive. In streamed tests it keeps a list of expected values and compares the operation issued three falling edges earlier. Expected values come from a 128-bit reference model in the bench. The flush test and the idle test check `res_vld` in each of the cycles where a cancelled or absent operation would otherwise have appeared.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam int XLEN_DEF = 64;

  typedef struct packed {
    logic a_hi;
    logic b_hi;
    logic sgn;
    logic narrow;
    logic nsext;
    logic acc;
  } wmac_op_t;

  typedef struct packed {
    logic narrow;
    logic nsext;
    logic acc;
  } wmac_tail_t;
endpackage

// File: rtl/wmac_opsel.sv
module wmac_opsel #(
  parameter int XLEN = wmac_pkg::XLEN_DEF,
  localparam int HW = XLEN / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [XLEN-1:0] src,
  input  logic          hi_sel,
  input  logic          sgn,
  output logic [HW:0]   op_q
);
  logic [HW-1:0] half;
  logic [HW:0]   op_d;

  always_comb begin
    half = hi_sel ? src[XLEN-1:HW] : src[HW-1:0];
    op_d = {sgn & half[HW-1], half};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  op_q <= '0;
    else if (en) op_q <= op_d;
  end

  // R3: the upper half is taken when selected
  a_r3_hi_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hi_sel) |=> (op_q[HW-1:0] == $past(src[XLEN-1:HW])));
  // R4: unsigned mode never yields a set extension bit
  a_r4_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sgn) |=> (op_q[HW] == 1'b0));
endmodule

// File: rtl/wmac_mult.sv
module wmac_mult #(
  parameter int XLEN = wmac_pkg::XLEN_DEF,
  localparam int HW = XLEN / 2,
  localparam int EXT = XLEN - HW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [HW:0]     a_op,
  input  logic [HW:0]     b_op,
  output logic [XLEN-1:0] prod_q
);
  logic signed [XLEN-1:0] a_x;
  logic signed [XLEN-1:0] b_x;
  logic signed [XLEN-1:0] prod_d;

  always_comb begin
    a_x    = {{EXT{a_op[HW]}}, a_op};
    b_x    = {{EXT{b_op[HW]}}, b_op};
    prod_d = a_x * b_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= prod_d;
  end

  // R5: a zero factor gives a zero product
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (a_op == '0 || b_op == '0)) |=> (prod_q == '0));
endmodule

// File: rtl/wmac_accum.sv
module wmac_accum #(
  parameter int XLEN = wmac_pkg::XLEN_DEF,
  localparam int HW = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] prod,
  input  logic [XLEN-1:0] addend,
  input  logic            acc,
  input  logic            narrow,
  input  logic            nsext,
  output logic [XLEN-1:0] res_q
);
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] res_d;

  always_comb begin
    sum = prod + (acc ? addend : '0);
    if (narrow) res_d = {{HW{nsext & sum[HW-1]}}, sum[HW-1:0]};
    else        res_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= res_d;
  end

  // R6: a zero-extended narrow result has a clear upper half
  a_r6_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (en && narrow && !nsext) |=> (res_q[XLEN-1:HW] == '0));
  // R6: a sign-extended narrow result repeats bit 31
  a_r6_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (en && narrow && nsext) |=> (res_q[XLEN-1:HW] == {HW{res_q[HW-1]}}));
  // R7: without accumulation a full result passes the product through
  a_r7_noacc: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !acc && !narrow) |=> (res_q == $past(prod)));
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit #(
  parameter int XLEN = wmac_pkg::XLEN_DEF,
  localparam int HW = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            op_vld,
  input  logic [5:0]      op_code,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] addend,
  output logic            res_vld,
  output logic [XLEN-1:0] res
);
  import wmac_pkg::*;

  wmac_op_t        op;
  logic            s1_v, s2_v;
  logic            s1_v_d, s2_v_d, s3_v_d;
  wmac_tail_t      s1_t, s2_t;
  logic [XLEN-1:0] s1_add, s2_add;
  logic [HW:0]     s1_a, s1_b;
  logic [XLEN-1:0] s2_prod;

  assign op = wmac_op_t'(op_code);

  // next-state for the valid pipeline
  always_comb begin
    s1_v_d = op_vld & ~flush;
    s2_v_d = s1_v & ~flush;
    s3_v_d = s2_v & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      s1_v    <= s1_v_d;
      s2_v    <= s2_v_d;
      res_vld <= s3_v_d;
    end
  end

  // side data moving alongside the operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_t   <= '0;
      s1_add <= '0;
    end else if (s1_v_d) begin
      s1_t   <= '{narrow: op.narrow, nsext: op.nsext, acc: op.acc};
      s1_add <= addend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_t   <= '0;
      s2_add <= '0;
    end else if (s2_v_d) begin
      s2_t   <= s1_t;
      s2_add <= s1_add;
    end
  end

  // stage 1: half select and extension, one selector per source
  for (genvar g = 0; g < 2; g++) begin : g_sel
    logic [HW:0] sel_q;
    wmac_opsel #(.XLEN(XLEN)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (s1_v_d),
      .src    ((g == 0) ? src_a : src_b),
      .hi_sel ((g == 0) ? op.a_hi : op.b_hi),
      .sgn    (op.sgn),
      .op_q   (sel_q)
    );
  end
  assign s1_a = g_sel[0].sel_q;
  assign s1_b = g_sel[1].sel_q;

  // stage 2: multiply
  wmac_mult #(.XLEN(XLEN)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (s2_v_d),
    .a_op   (s1_a),
    .b_op   (s1_b),
    .prod_q (s2_prod)
  );

  // stage 3: accumulate and narrow
  wmac_accum #(.XLEN(XLEN)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (s3_v_d),
    .prod   (s2_prod),
    .addend (s2_add),
    .acc    (s2_t.acc),
    .narrow (s2_t.narrow),
    .nsext  (s2_t.nsext),
    .res_q  (res)
  );

  // R9: a flush leaves nothing valid on the following cycle
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!res_vld && !s1_v && !s2_v));
  // R2: an operation in the multiply stage reaches the output next cycle
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !flush) |=> res_vld);
  // R10: no result without an operation one stage back
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_v |=> !res_vld);
endmodule

// File: tb/wmac_unit_tb.sv
module wmac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        op_vld;
  logic [5:0]  op_code;
  logic [63:0] src_a, src_b, addend;
  logic        res_vld;
  logic [63:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] qa [256];
  logic [63:0] qb [256];
  logic [63:0] qc [256];
  logic [5:0]  qo [256];

  always #2 clk = ~clk;

  wmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .op_vld(op_vld),
    .op_code(op_code), .src_a(src_a), .src_b(src_b), .addend(addend),
    .res_vld(res_vld), .res(res)
  );

  function automatic logic [5:0] mkop(bit ah, bit bh, bit sg, bit nr, bit ns, bit ac);
    return {ah, bh, sg, nr, ns, ac};
  endfunction

  function automatic logic [63:0] ref_f(logic [63:0] a, logic [63:0] b,
                                        logic [63:0] c, logic [5:0] o);
    logic [31:0]  ha, hb;
    logic [127:0] x, y, p;
    logic [63:0]  s;
    ha = o[5] ? a[63:32] : a[31:0];
    hb = o[4] ? b[63:32] : b[31:0];
    x  = o[3] ? {{96{ha[31]}}, ha} : {96'd0, ha};
    y  = o[3] ? {{96{hb[31]}}, hb} : {96'd0, hb};
    p  = x * y;
    s  = p[63:0] + (o[0] ? c : 64'd0);
    if (o[2]) s = o[1] ? {{32{s[31]}}, s[31:0]} : {32'd0, s[31:0]};
    return s;
  endfunction

  task automatic chk64(logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] c, logic [5:0] o);
    op_vld = 1'b1; src_a = a; src_b = b; addend = c; op_code = o;
  endtask

  task automatic idle();
    op_vld = 1'b0; src_a = '0; src_b = '0; addend = '0; op_code = '0;
  endtask

  task automatic do_one(logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        logic [5:0] o, logic [63:0] exp, string tag);
    @(negedge clk); drive(a, b, c, o);
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    chk1(res_vld, 1'b1, {tag, " valid"});
    chk64(res, exp, tag);
  endtask

  task automatic run_stream(int n, string tag);
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        chk1(res_vld, 1'b1, {tag, " valid"});
        chk64(res, ref_f(qa[c-3], qb[c-3], qc[c-3], qo[c-3]), tag);
      end
      if (c < n) drive(qa[c], qb[c], qc[c], qo[c]);
      else idle();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; flush = 1'b0; idle();
    repeat (3) @(negedge clk);
    chk1(res_vld, 1'b0, "R1 res_vld in reset");
    chk64(res, 64'd0, "R1 res in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk1(res_vld, 1'b0, "R1 res_vld after reset");
    chk64(res, 64'd0, "R1 res after reset");
  endtask

  task automatic t_halves();
    logic [63:0] a = 64'h00000003_00000005;
    logic [63:0] b = 64'h00000007_0000000B;
    do_one(a, b, 0, mkop(0,0,0,0,0,0), 64'd55, "R3 lo x lo");
    do_one(a, b, 0, mkop(1,0,0,0,0,0), 64'd33, "R3 a_hi x b_lo");
    do_one(a, b, 0, mkop(0,1,0,0,0,0), 64'd35, "R3 a_lo x b_hi");
    do_one(a, b, 0, mkop(1,1,1,0,0,0), 64'd21, "R3 hi x hi signed");
  endtask

  task automatic t_sign();
    do_one(64'h00000000_FFFFFFFF, 64'd2, 0, mkop(0,0,1,0,0,0),
           64'hFFFFFFFF_FFFFFFFE, "R4 signed");
    do_one(64'h00000000_FFFFFFFF, 64'd2, 0, mkop(0,0,0,0,0,0),
           64'h00000001_FFFFFFFE, "R4 unsigned");
    do_one(64'h80000000_00000000, 64'h80000000_00000000, 0, mkop(1,1,1,0,0,0),
           64'h40000000_00000000, "R5 signed min x min full");
  endtask

  task automatic t_narrow();
    do_one(64'h10000, 64'h8000, 0, mkop(0,0,1,0,0,0), 64'h00000000_80000000, "R5 full");
    do_one(64'h10000, 64'h8000, 0, mkop(0,0,1,1,1,0), 64'hFFFFFFFF_80000000, "R6 narrow sext");
    do_one(64'h10000, 64'h8000, 0, mkop(0,0,1,1,0,0), 64'h00000000_80000000, "R6 narrow zext");
  endtask

  task automatic t_acc();
    do_one(64'd1, 64'd1, 64'hFFFFFFFF_FFFFFFFF, mkop(0,0,0,0,0,1), 64'd0, "R7 wrap");
    do_one(64'd1, 64'd1, 64'h00000000_7FFFFFFF, mkop(0,0,0,1,1,1),
           64'hFFFFFFFF_80000000, "R7 add before narrow");
    do_one(64'd1, 64'd1, 64'h00000000_7FFFFFFF, mkop(0,0,0,0,0,0),
           64'd1, "R7 addend ignored when off");
  endtask

  task automatic t_imm();
    do_one(64'd16, 64'd1280, 64'd100, mkop(0,0,0,0,0,1), 64'h5064, "R8 immediate mac");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) begin
      qa[i] = {$urandom, $urandom}; qb[i] = {$urandom, $urandom};
      qc[i] = {$urandom, $urandom}; qo[i] = 6'($urandom);
    end
    run_stream(40, "R2 back-to-back");
  endtask

  task automatic t_flush();
    @(negedge clk); drive(64'd3, 64'd3, 0, 0);
    @(negedge clk); drive(64'd4, 64'd4, 0, 0);
    @(negedge clk); drive(64'd5, 64'd5, 0, 0); flush = 1'b1;
    @(negedge clk); idle(); flush = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk1(res_vld, 1'b0, "R9 flushed op gone");
      @(negedge clk);
    end
    do_one(64'd6, 64'd7, 0, 0, 64'd42, "R9 recovery after flush");
  endtask

  task automatic t_idle();
    idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk1(res_vld, 1'b0, "R10 idle no valid");
    end
  endtask

  task automatic t_corners();
    logic [31:0] cv [4];
    cv[0] = 32'h0; cv[1] = 32'hFFFFFFFF; cv[2] = 32'h80000000; cv[3] = 32'h7FFFFFFF;
    for (int g = 0; g < 4; g++) begin
      for (int o = 0; o < 16; o++) begin
        for (int p = 0; p < 16; p++) begin
          int k = o * 16 + p;
          qa[k] = {cv[p % 4], cv[3 - (p % 4)]};
          qb[k] = {cv[p / 4], cv[(p / 4 + 1) % 4]};
          qc[k] = (p % 3 == 0) ? 64'hFFFFFFFF_FFFFFFFF : {$urandom, $urandom};
          qo[k] = 6'(g * 16 + o);
        end
      end
      run_stream(256, "R3/R4/R5/R6/R7 corner");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_halves();
    t_sign();
    t_narrow();
    t_acc();
    t_imm();
    t_stream();
    t_flush();
    t_idle();
    t_corners();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule